// File: doc/BRIEF.md
# Register Rename with Free Pool

This block maps 32 logical registers onto 64 physical registers for an in-order front end that renames up to two instructions per cycle. A speculative map answers every source lookup and takes the new destination tags. A committed map records the state at retirement. A free pool holds the physical registers that no instruction owns.

For each renamed instruction the block returns:
- the physical tags of both sources;
- a newly allocated destination tag;
- the tag that the destination logical register held before, so that the caller can release it at retirement.

On commit the caller presents the logical destination, the new tag and the old tag. The committed map takes the new tag and the old tag goes back to the pool. On a flush the speculative map is reloaded from the committed map and the pool is rebuilt to match it. This discards every allocation that was still in flight.

Logical register Rn is encoded as index n-1 (0 to 31). Physical register Pn is encoded as index n-1 (0 to 63). All tags at the ports use these indices.

Top module: `rr_rename`

## Requirements
- R1: After reset, logical index i reads as physical index i for i = 0..31, and the pool holds exactly indices 32..63.
- R2: Destinations receive the lowest-indexed free physical registers. Lane 0 is served before lane 1, and only lanes with rn_has_dst set consume a register. After reset the first destination is index 32, then 33.
- R3: A source lookup returns the newest speculative mapping, including those made by earlier accepted groups. rn_pold returns the mapping that the destination held before this group.
- R4: When a lane-1 source or destination names the same logical register as the lane-0 destination in the same group, it sees the lane-0 new tag (as rn_psrc or rn_pold).
- R5: A group is accepted (rn_accept) only if rn_valid is set, flush is low and the pool holds at least as many registers as the group has destinations. A rejected or invalid group changes neither map nor pool. A valid group with no destinations is always accepted outside a flush.
- R6: A commit writes cm_pnew into the committed map entry cm_ldst. It leaves the speculative map untouched.
- R7: A commit returns cm_pold to the pool, and it can be allocated from the next cycle on.
- R8: A flush sets the speculative map equal to the committed map, including a commit in the same cycle, and rebuilds the pool as its complement. A rename presented in the flush cycle is ignored.
- R9: At most 32 physical registers are allocated and not yet committed. When all are taken, a group with destinations stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_valid | input | 1 | A rename group is presented |
| rn_has_dst | input | 2 | Per lane: the instruction writes a destination |
| rn_ldst | input | 2x5 | Per lane logical destination |
| rn_lsrc1 | input | 2x5 | Per lane first logical source |
| rn_lsrc2 | input | 2x5 | Per lane second logical source |
| rn_accept | output | 1 | Group accepted this cycle |
| rn_pdst | output | 2x6 | Per lane newly allocated physical destination |
| rn_pold | output | 2x6 | Per lane previous mapping of the destination |
| rn_psrc1 | output | 2x6 | Per lane first physical source |
| rn_psrc2 | output | 2x6 | Per lane second physical source |
| cm_valid | input | 1 | A retiring instruction is presented |
| cm_ldst | input | 5 | Logical destination of the retiring instruction |
| cm_pnew | input | 6 | Physical tag it was given |
| cm_pold | input | 6 | Physical tag it displaced, to be freed |
| flush | input | 1 | Discard all speculative state |

## Verification
A corrupted speculative map entry shows up as a wrong rn_psrc or rn_pold on the first lookup of that register, in the same cycle. A pool that loses or duplicates a bit shows up as a wrong rn_pdst on the next allocation, or as a stall or missing stall once the pool drains. Errors in the committed map stay hidden until a flush, so every flush is followed at once by lookups and allocations whose values depend on the commits made before it.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int NUM_LOG  = 32;
    localparam int NUM_PHYS = 64;
    localparam int RN_W     = 2;
    localparam int LOG_W    = $clog2(NUM_LOG);
    localparam int PHY_W    = $clog2(NUM_PHYS);
    localparam int SPARE    = NUM_PHYS - NUM_LOG;

    typedef logic [LOG_W-1:0]    ltag_t;
    typedef logic [PHY_W-1:0]    ptag_t;
    typedef logic [NUM_PHYS-1:0] pvec_t;
    typedef ptag_t [NUM_LOG-1:0] map_t;

    typedef struct packed {
        logic  hit;
        ptag_t tag;
    } pick_t;

    typedef struct packed {
        logic  en;
        ltag_t ldst;
        ptag_t ptag;
    } map_wr_t;

    typedef struct packed {
        logic  en;
        ltag_t ldst;
        ptag_t pnew;
        ptag_t pold;
    } commit_t;

    function automatic pick_t lowest_free(pvec_t v);
        pick_t r;
        r = '0;
        for (int p = NUM_PHYS - 1; p >= 0; p--) begin
            if (v[p]) begin
                r.hit = 1'b1;
                r.tag = ptag_t'(p);
            end
        end
        return r;
    endfunction

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < NUM_LOG; i++) m[i] = ptag_t'(i);
        return m;
    endfunction

    function automatic pvec_t spare_pool();
        pvec_t v;
        for (int p = 0; p < NUM_PHYS; p++) v[p] = (p >= NUM_LOG);
        return v;
    endfunction
endpackage

// File: rtl/rr_commit_map.sv
module rr_commit_map import rr_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  commit_t cm,
    output map_t    cmap_q,
    output map_t    cmap_nxt,
    output pvec_t   cfree_q,
    output pvec_t   cfree_nxt
);
    always_comb begin
        cmap_nxt  = cmap_q;
        cfree_nxt = cfree_q;
        if (cm.en) begin
            cmap_nxt[cm.ldst]  = cm.pnew;
            cfree_nxt[cm.pnew] = 1'b0;
            cfree_nxt[cm.pold] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmap_q  <= identity_map();
            cfree_q <= spare_pool();
        end else begin
            cmap_q  <= cmap_nxt;
            cfree_q <= cfree_nxt;
        end
    end

    assert_commit_write_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(cm.en) && !$past(rst)) |-> (cmap_q[$past(cm.ldst)] == $past(cm.pnew)));
endmodule

// File: rtl/rr_spec_map.sv
module rr_spec_map import rr_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  map_wr_t [RN_W-1:0]      wr,
    input  logic                    flush,
    input  map_t                    flush_map,
    output map_t                    map_q
);
    map_t map_d;

    always_comb begin
        map_d = map_q;
        if (flush) begin
            map_d = flush_map;
        end else begin
            for (int l = 0; l < RN_W; l++) begin
                if (wr[l].en) map_d[wr[l].ldst] = wr[l].ptag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= identity_map();
        else     map_q <= map_d;
    end
endmodule

// File: rtl/rr_free_pool.sv
module rr_free_pool import rr_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RN_W-1:0]       want,
    input  logic                  take,
    input  logic                  flush,
    input  pvec_t                 flush_vec,
    input  logic                  rel_en,
    input  ptag_t                 rel_tag,
    output pick_t [RN_W-1:0]      grant,
    output logic                  grant_ok,
    output pvec_t                 free_q
);
    pvec_t remain;
    pvec_t free_d;

    always_comb begin
        remain   = free_q;
        grant_ok = 1'b1;
        for (int l = 0; l < RN_W; l++) begin
            grant[l] = '0;
            if (want[l]) begin
                grant[l] = lowest_free(remain);
                if (grant[l].hit) remain[grant[l].tag] = 1'b0;
                else              grant_ok = 1'b0;
            end
        end
    end

    always_comb begin
        if (flush) begin
            free_d = flush_vec;
        end else begin
            free_d = take ? remain : free_q;
            if (rel_en) free_d[rel_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= spare_pool();
        else     free_q <= free_d;
    end

    assert_pool_bound_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(free_q) <= SPARE);

    assert_lowest_first_R2: assert property (@(posedge clk) disable iff (rst)
        (want[0] && grant[0].hit) |->
            (free_q[grant[0].tag] && ((free_q & ((pvec_t'(1) << grant[0].tag) - pvec_t'(1))) == '0)));

    assert_distinct_grants_R2: assert property (@(posedge clk) disable iff (rst)
        (want[0] && want[1] && grant_ok) |-> (grant[0].tag != grant[1].tag));
endmodule

// File: rtl/rr_rename.sv
module rr_rename import rr_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rn_valid,
    input  logic [RN_W-1:0]             rn_has_dst,
    input  logic [RN_W-1:0][LOG_W-1:0]  rn_ldst,
    input  logic [RN_W-1:0][LOG_W-1:0]  rn_lsrc1,
    input  logic [RN_W-1:0][LOG_W-1:0]  rn_lsrc2,
    output logic                        rn_accept,
    output logic [RN_W-1:0][PHY_W-1:0]  rn_pdst,
    output logic [RN_W-1:0][PHY_W-1:0]  rn_pold,
    output logic [RN_W-1:0][PHY_W-1:0]  rn_psrc1,
    output logic [RN_W-1:0][PHY_W-1:0]  rn_psrc2,
    input  logic                        cm_valid,
    input  logic [LOG_W-1:0]            cm_ldst,
    input  logic [PHY_W-1:0]            cm_pnew,
    input  logic [PHY_W-1:0]            cm_pold,
    input  logic                        flush
);
    commit_t          cm;
    map_t             cmap_q, cmap_nxt, spec_q;
    pvec_t            cfree_q, cfree_nxt, free_vec;
    pick_t [RN_W-1:0] grant;
    logic             grant_ok;
    logic [RN_W-1:0]  want;
    map_wr_t [RN_W-1:0] wr;

    assign cm   = '{en: cm_valid, ldst: cm_ldst, pnew: cm_pnew, pold: cm_pold};
    assign want = rn_has_dst & {RN_W{rn_valid}};
    assign rn_accept = rn_valid && grant_ok && !flush;

    rr_commit_map u_cmap (
        .clk(clk), .rst(rst), .cm(cm),
        .cmap_q(cmap_q), .cmap_nxt(cmap_nxt),
        .cfree_q(cfree_q), .cfree_nxt(cfree_nxt)
    );

    rr_free_pool u_pool (
        .clk(clk), .rst(rst), .want(want), .take(rn_accept),
        .flush(flush), .flush_vec(cfree_nxt),
        .rel_en(cm_valid), .rel_tag(cm_pold),
        .grant(grant), .grant_ok(grant_ok), .free_q(free_vec)
    );

    rr_spec_map u_smap (
        .clk(clk), .rst(rst), .wr(wr), .flush(flush),
        .flush_map(cmap_nxt), .map_q(spec_q)
    );

    // Lookup per lane with forwarding from older lanes of the same group
    generate
        for (genvar l = 0; l < RN_W; l++) begin : g_lane
            always_comb begin
                rn_pdst[l]  = grant[l].tag;
                rn_psrc1[l] = spec_q[rn_lsrc1[l]];
                rn_psrc2[l] = spec_q[rn_lsrc2[l]];
                rn_pold[l]  = spec_q[rn_ldst[l]];
                for (int k = 0; k < l; k++) begin
                    if (rn_has_dst[k]) begin
                        if (rn_ldst[k] == rn_lsrc1[l]) rn_psrc1[l] = grant[k].tag;
                        if (rn_ldst[k] == rn_lsrc2[l]) rn_psrc2[l] = grant[k].tag;
                        if (rn_ldst[k] == rn_ldst[l])  rn_pold[l]  = grant[k].tag;
                    end
                end
                wr[l] = '{en: rn_accept && rn_has_dst[l], ldst: rn_ldst[l], ptag: grant[l].tag};
            end
        end
    endgenerate

    assert_stall_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (rn_valid && (|rn_has_dst) && (free_vec == '0)) |-> !rn_accept);

    assert_flush_restore_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && !$past(rst)) |-> ((spec_q == cmap_q) && (free_vec == cfree_q)));
endmodule

// File: tb/tb_rr_rename.sv
module tb_rr_rename;
    import rr_pkg::*;
    localparam int CLK_P = 10;

    logic clk = 0, rst = 1;
    logic rn_valid = 0, rn_accept, cm_valid = 0, flush = 0;
    logic [RN_W-1:0] rn_has_dst = '0;
    logic [RN_W-1:0][LOG_W-1:0] rn_ldst = '0, rn_lsrc1 = '0, rn_lsrc2 = '0;
    logic [RN_W-1:0][PHY_W-1:0] rn_pdst, rn_pold, rn_psrc1, rn_psrc2;
    logic [LOG_W-1:0] cm_ldst = '0;
    logic [PHY_W-1:0] cm_pnew = '0, cm_pold = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    rr_rename dut (.*);

    typedef struct packed {
        logic v, h0, h1;
        logic [4:0] d0, a0, b0, d1, a1, b1;
        logic acc;
        logic [5:0] e0d, e0o, e0a, e0b, e1d, e1o, e1a, e1b;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{1,1,1, 1,2,3, 4,1,5, 1, 32,1,2,3,    33,4,32,5},   // R2 R4
        '{1,1,1, 1,1,4, 1,1,4, 1, 34,32,32,33, 35,34,34,33}, // R3 R4
        '{1,0,1, 0,1,7, 7,0,7, 1, 0,0,35,7,    36,7,0,7},    // R2 lane1 only
        '{0,1,0, 2,0,0, 0,0,0, 0, 0,0,0,0,     0,0,0,0},     // R5 invalid
        '{1,1,0, 2,7,2, 0,2,1, 1, 37,2,36,2,   0,0,37,35}    // R4 R5
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(bit v, bit h0, bit h1, int d0, int a0, int b0, int d1, int a1, int b1);
        @(negedge clk);
        rn_valid = v; rn_has_dst = {h1, h0};
        rn_ldst[0] = 5'(d0); rn_lsrc1[0] = 5'(a0); rn_lsrc2[0] = 5'(b0);
        rn_ldst[1] = 5'(d1); rn_lsrc1[1] = 5'(a1); rn_lsrc2[1] = 5'(b1);
        #1;
    endtask

    task automatic commit_drive(int l, int pn, int po, bit fl);
        cm_valid = 1; cm_ldst = 5'(l); cm_pnew = 6'(pn); cm_pold = 6'(po); flush = fl;
    endtask

    task automatic edge_clear();
        @(posedge clk);
        #1;
        cm_valid = 0; flush = 0; rn_valid = 0; rn_has_dst = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        drive(0,0,0, 0,0,31, 0,5,17);
        chk("R1 src L0", rn_psrc1[0], 0);
        chk("R1 src L31", rn_psrc2[0], 31);
        chk("R1 src L5", rn_psrc1[1], 5);
        chk("R1 src L17", rn_psrc2[1], 17);
        edge_clear();

        foreach (TBL[i]) begin
            drive(TBL[i].v, TBL[i].h0, TBL[i].h1, TBL[i].d0, TBL[i].a0, TBL[i].b0,
                  TBL[i].d1, TBL[i].a1, TBL[i].b1);
            chk("R5 accept", rn_accept, TBL[i].acc);
            if (TBL[i].acc) begin
                chk("R3 l0 src1", rn_psrc1[0], TBL[i].e0a);
                chk("R3 l0 src2", rn_psrc2[0], TBL[i].e0b);
                chk("R4 l1 src1", rn_psrc1[1], TBL[i].e1a);
                chk("R4 l1 src2", rn_psrc2[1], TBL[i].e1b);
                if (TBL[i].h0) begin
                    chk("R2 l0 dst", rn_pdst[0], TBL[i].e0d);
                    chk("R3 l0 old", rn_pold[0], TBL[i].e0o);
                end
                if (TBL[i].h1) begin
                    chk("R2 l1 dst", rn_pdst[1], TBL[i].e1d);
                    chk("R4 l1 old", rn_pold[1], TBL[i].e1o);
                end
            end
            edge_clear();
        end

        // R6: commit leaves speculative map alone
        drive(0,0,0, 0,0,0, 0,0,0);
        commit_drive(1, 32, 1, 0);
        edge_clear();
        drive(0,0,0, 0,1,4, 0,0,0);
        chk("R6 spec L1 kept", rn_psrc1[0], 35);
        chk("R6 spec L4 kept", rn_psrc2[0], 33);
        edge_clear();

        // R8 flush, then R7 reuse of freed index 1
        drive(0,0,0, 0,0,0, 0,0,0);
        flush = 1;
        edge_clear();
        drive(1,1,1, 3,1,4, 5,7,2);
        chk("R8 L1 from commit", rn_psrc1[0], 32);
        chk("R8 L4 restored", rn_psrc2[0], 4);
        chk("R8 L7 restored", rn_psrc1[1], 7);
        chk("R8 L2 restored", rn_psrc2[1], 2);
        chk("R7 freed reused", rn_pdst[0], 1);
        chk("R8 l0 old", rn_pold[0], 3);
        chk("R8 pool rebuilt", rn_pdst[1], 33);
        chk("R8 l1 old", rn_pold[1], 5);
        chk("R8 accept", rn_accept, 1);
        edge_clear();

        // R9: drain the pool
        for (int k = 0; k < 29; k++) begin
            drive(1,1,0, 10,10,0, 0,0,0);
            chk("R9 drain accept", rn_accept, 1);
            chk("R9 drain dst", rn_pdst[0], 34 + k);
            chk("R3 chain old", rn_pold[0], (k == 0) ? 10 : 33 + k);
            edge_clear();
        end
        drive(1,1,1, 11,0,0, 11,0,0);
        chk("R5 all or nothing", rn_accept, 0);
        edge_clear();
        drive(1,0,1, 0,0,0, 11,11,0);
        chk("R2 lane1 last reg", rn_pdst[1], 63);
        chk("R2 lane1 accept", rn_accept, 1);
        edge_clear();
        drive(1,1,0, 12,11,0, 0,0,0);
        chk("R9 stall empty", rn_accept, 0);
        chk("R5 rejected no change", rn_psrc1[0], 63);
        edge_clear();
        drive(1,0,0, 0,12,0, 0,0,0);
        chk("R5 no-dst accepted", rn_accept, 1);
        chk("R5 rejected map kept", rn_psrc1[0], 12);
        edge_clear();

        // R7: commit release usable next cycle
        drive(0,0,0, 0,0,0, 0,0,0);
        commit_drive(3, 1, 3, 0);
        edge_clear();
        drive(1,1,0, 12,0,0, 0,0,0);
        chk("R7 release accept", rn_accept, 1);
        chk("R7 release dst", rn_pdst[0], 3);
        chk("R7 old", rn_pold[0], 12);
        edge_clear();

        // R8: flush with same-cycle commit, rename ignored
        drive(1,1,0, 5,5,0, 0,0,0);
        commit_drive(5, 33, 5, 1);
        #1;
        chk("R8 rename in flush", rn_accept, 0);
        edge_clear();
        drive(0,0,0, 0,5,10, 0,11,3);
        chk("R8 same-cycle commit", rn_psrc1[0], 33);
        chk("R8 L10 restored", rn_psrc2[0], 10);
        chk("R8 L11 restored", rn_psrc1[1], 11);
        chk("R8 L3 committed", rn_psrc2[1], 1);
        edge_clear();
        drive(1,1,1, 20,0,0, 21,0,0);
        chk("R8 pool l0", rn_pdst[0], 3);
        chk("R8 pool l1", rn_pdst[1], 5);
        chk("R8 pool accept", rn_accept, 1);
        edge_clear();

        finish_run();
    end
endmodule